// File: doc/BRIEF.md
# Floating-Point Compare Predicate Unit

This block evaluates one floating-point compare operation per cycle. It takes two IEEE-754 operands, either single or double precision, together with a 6-bit compare function code and a 3-bit condition-code index. It works out whether the operands are unordered, equal or ordered less-than. A predicate mask taken from the function code ORs together the relations it enables, and the result is a single condition bit. That bit is written back, with its index, one clock after the request.

A signaling form of every compare turns an unordered outcome into an invalid-operation exception. A signaling NaN operand raises the same exception for any compare. If the invalid exception is enabled for trapping and the compare raises it, the condition-code write is suppressed while the exception indication still goes out. Zeros of either sign compare equal. Infinities and finite values are ordered by sign and then magnitude.

Top module: `fcmp_pred_unit`

## Requirements
- R1: A request with `valid_i` high and `func_i` in 48..63 (`func_i[5:4]` = 2'b11) produces its result on the outputs after the next rising clock, with `cc_idx_o` equal to the requested index. Any other request, or no request, leaves `cc_we_o`, `cc_val_o`, `inv_o` and `cc_idx_o` at zero in that cycle. `cc_val_o` is zero whenever `cc_we_o` is zero.
- R2: The predicate is `func_i` minus 48. Its bits [2:0] are a mask in which bit 0 enables unordered, bit 1 enables equal and bit 2 enables less-than (first operand below second). The condition bit is true when any enabled relation holds.
- R3: Mask 0 always gives false. Mask 7 gives true except when the first operand is strictly greater than the second.
- R4: An operand whose exponent field is all ones and whose fraction is nonzero is a NaN and makes the pair unordered. Unordered pairs are never equal or less-than. The fraction MSB set marks a quiet NaN and clear marks a signaling NaN.
- R5: Predicate bit 3 (`func_i[3]`) marks a signaling compare. A signaling compare on an unordered pair raises `inv_o`.
- R6: A signaling NaN in either operand raises `inv_o` for every compare code, signaling or not. A quiet NaN raises nothing under a non-signaling code.
- R7: Positive zero and negative zero compare equal and neither is less than the other.
- R8: Non-NaN operands are ordered by sign, then magnitude: negatives below positives, larger magnitude lower among negatives, infinities at the ends.
- R9: When `inv_trap_en_i` is high and the compare raises `inv_o`, `cc_we_o` stays low while `inv_o` is still reported.
- R10: `fmt_i` = 0 selects single precision on bits [31:0] of each operand, and bits [63:32] have no effect. `fmt_i` = 1 selects double precision on all 64 bits.
- R11: While `rst_ni` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| fmt_i | input | 1 | 0 single, 1 double precision |
| func_i | input | 6 | Compare function code (48..63) |
| cc_idx_i | input | 3 | Destination condition-code index |
| op_a_i | input | 64 | First operand |
| op_b_i | input | 64 | Second operand |
| inv_trap_en_i | input | 1 | Invalid exception enabled for trapping |
| cc_we_o | output | 1 | Condition-code write strobe |
| cc_idx_o | output | 3 | Condition-code index of the write |
| cc_val_o | output | 1 | Condition result bit |
| inv_o | output | 1 | Invalid-operation exception |

## Verification
The hardest case to reach from the ports is a signaling NaN meeting a non-signaling predicate while trapping is enabled. In that case the exception must come out and the write must be dropped, even though the mask alone would have produced a valid result. Random operands almost never hit NaN encodings, so the stimulus draws each operand from a pool of encoded specials in both formats: signed zeros, infinities, quiet and signaling NaNs, and neighbouring finite values. It crosses these with all sixteen predicate codes and both trap settings. Single-precision requests also carry junk in the upper operand halves.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int OP_W     = 64;
  localparam int MAG_W    = OP_W - 1;
  localparam int SP_W     = 32;
  localparam int SP_EXP   = 8;
  localparam int SP_FRAC  = 23;
  localparam int DP_EXP   = 11;
  localparam int DP_FRAC  = 52;
  localparam int FUNC_W   = 6;
  localparam int MASK_W   = 3;

  typedef struct packed {
    logic             sign;
    logic [MAG_W-1:0] mag;
    logic             nan;
    logic             snan;
    logic             zero;
  } opnd_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
(
  input  logic            dbl_i,
  input  logic [OP_W-1:0] op_i,
  output opnd_t           cls_o
);
  localparam int SP_MAG = SP_W - 1;

  logic             sign, exp_ones, frac_nz, qbit;
  logic [MAG_W-1:0] mag;

  always_comb begin
    if (dbl_i) begin
      sign     = op_i[OP_W-1];
      mag      = op_i[MAG_W-1:0];
      exp_ones = &op_i[MAG_W-1 -: DP_EXP];
      frac_nz  = |op_i[DP_FRAC-1:0];
      qbit     = op_i[DP_FRAC-1];
    end else begin
      sign     = op_i[SP_W-1];
      mag      = {{(MAG_W-SP_MAG){1'b0}}, op_i[SP_MAG-1:0]};
      exp_ones = &op_i[SP_MAG-1 -: SP_EXP];
      frac_nz  = |op_i[SP_FRAC-1:0];
      qbit     = op_i[SP_FRAC-1];
    end
    cls_o.sign = sign;
    cls_o.mag  = mag;
    cls_o.nan  = exp_ones & frac_nz;
    cls_o.snan = exp_ones & frac_nz & ~qbit;
    cls_o.zero = (mag == '0);
  end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
(
  input  opnd_t a_i,
  input  opnd_t b_i,
  output logic  unord_o,
  output logic  eq_o,
  output logic  lt_o
);
  logic mag_lt, mag_gt, mag_eq;

  assign mag_lt = a_i.mag < b_i.mag;
  assign mag_gt = a_i.mag > b_i.mag;
  assign mag_eq = a_i.mag == b_i.mag;

  always_comb begin
    unord_o = a_i.nan | b_i.nan;
    // signed zeros collapse to equal
    eq_o    = ~unord_o & ((a_i.zero & b_i.zero) | ((a_i.sign == b_i.sign) & mag_eq));
    if (unord_o || eq_o)            lt_o = 1'b0;
    else if (a_i.sign != b_i.sign)  lt_o = a_i.sign;
    else if (a_i.sign)              lt_o = mag_gt;
    else                            lt_o = mag_lt;
  end
endmodule

// File: rtl/fcmp_pred_unit.sv
module fcmp_pred_unit
  import fcmp_pkg::*;
#(
  parameter int CC_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              fmt_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [CC_W-1:0]   cc_idx_i,
  input  logic [OP_W-1:0]   op_a_i,
  input  logic [OP_W-1:0]   op_b_i,
  input  logic              inv_trap_en_i,
  output logic              cc_we_o,
  output logic [CC_W-1:0]   cc_idx_o,
  output logic              cc_val_o,
  output logic              inv_o
);
  logic [OP_W-1:0] ops [2];
  opnd_t           cls [2];

  assign ops[0] = op_a_i;
  assign ops[1] = op_b_i;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fcmp_classify u_cls (
      .dbl_i (fmt_i),
      .op_i  (ops[i]),
      .cls_o (cls[i])
    );
  end

  logic unord, eq, lt;

  fcmp_order u_ord (
    .a_i     (cls[0]),
    .b_i     (cls[1]),
    .unord_o (unord),
    .eq_o    (eq),
    .lt_o    (lt)
  );

  logic              is_cmp, sig_cmp, pred, inv_d, we_d;
  logic [MASK_W-1:0] mask;

  assign is_cmp  = valid_i & (func_i[FUNC_W-1:FUNC_W-2] == 2'b11);
  assign sig_cmp = func_i[MASK_W];
  assign mask    = func_i[MASK_W-1:0];
  assign pred    = |(mask & {lt, eq, unord});
  assign inv_d   = is_cmp & ((sig_cmp & unord) | cls[0].snan | cls[1].snan);
  assign we_d    = is_cmp & ~(inv_d & inv_trap_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cc_we_o  <= 1'b0;
      cc_idx_o <= '0;
      cc_val_o <= 1'b0;
      inv_o    <= 1'b0;
    end else begin
      cc_we_o  <= we_d;
      cc_idx_o <= is_cmp ? cc_idx_i : '0;
      cc_val_o <= we_d & pred;
      inv_o    <= inv_d;
    end
  end
endmodule

// File: rtl/fcmp_pred_unit_chk.sv
module fcmp_pred_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic       fmt_i,
  input logic [5:0] func_i,
  input logic [2:0] cc_idx_i,
  input logic [8:0] a_top_i,
  input logic       inv_trap_en_i,
  input logic       cc_we_o,
  input logic [2:0] cc_idx_o,
  input logic       cc_val_o,
  input logic       inv_o
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!cc_we_o && !inv_o && !cc_val_o));
  // R1
  noncmp_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && func_i[5:4] != 2'b11) |=> (!cc_we_o && !inv_o));
  // R1
  idx_echo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && func_i[5:4] == 2'b11) |=> (cc_idx_o == $past(cc_idx_i)));
  // R1
  val_needs_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cc_we_o |-> !cc_val_o);
  // R3
  mask_zero_false_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && func_i[5:4] == 2'b11 && func_i[2:0] == 3'd0) |=> !cc_val_o);
  // R5
  sig_qnan_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && func_i[5:3] == 3'b111 && !fmt_i && (&a_top_i)) |=> inv_o);
  // R9
  trap_blocks_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && inv_trap_en_i) |=> !(cc_we_o && inv_o));
endmodule

bind fcmp_pred_unit fcmp_pred_unit_chk chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .valid_i       (valid_i),
  .fmt_i         (fmt_i),
  .func_i        (func_i),
  .cc_idx_i      (cc_idx_i),
  .a_top_i       (op_a_i[30:22]),
  .inv_trap_en_i (inv_trap_en_i),
  .cc_we_o       (cc_we_o),
  .cc_idx_o      (cc_idx_o),
  .cc_val_o      (cc_val_o),
  .inv_o         (inv_o)
);

// File: tb/fcmp_pred_unit_tb_top.sv
`timescale 1ns/1ps
module fcmp_pred_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, fmt_i = 1'b0, inv_trap_en_i = 1'b0;
  logic [5:0]  func_i = '0;
  logic [2:0]  cc_idx_i = '0;
  logic [63:0] op_a_i = '0, op_b_i = '0;
  logic        cc_we_o, cc_val_o, inv_o;
  logic [2:0]  cc_idx_o;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  fcmp_pred_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .fmt_i(fmt_i),
    .func_i(func_i), .cc_idx_i(cc_idx_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
    .inv_trap_en_i(inv_trap_en_i), .cc_we_o(cc_we_o), .cc_idx_o(cc_idx_o),
    .cc_val_o(cc_val_o), .inv_o(inv_o)
  );

  // reference: {we, idx[2:0], val, inv}
  function automatic logic [5:0] model(input logic v, input logic d, input logic [5:0] fn,
                                       input logic [2:0] ix, input logic [63:0] a,
                                       input logic [63:0] b, input logic tr);
    logic na, nb, sa, sb, un, eq, lt, cmp, inv, we, val;
    longint ka, kb;
    logic [62:0] ma, mb;
    if (d) begin
      na = (a[62:52] == 11'h7ff) && (a[51:0] != 0); sa = na && !a[51];
      nb = (b[62:52] == 11'h7ff) && (b[51:0] != 0); sb = nb && !b[51];
      ma = a[62:0]; mb = b[62:0];
      ka = a[63] ? -longint'(ma) : longint'(ma);
      kb = b[63] ? -longint'(mb) : longint'(mb);
    end else begin
      na = (a[30:23] == 8'hff) && (a[22:0] != 0); sa = na && !a[22];
      nb = (b[30:23] == 8'hff) && (b[22:0] != 0); sb = nb && !b[22];
      ka = a[31] ? -longint'(a[30:0]) : longint'(a[30:0]);
      kb = b[31] ? -longint'(b[30:0]) : longint'(b[30:0]);
    end
    un  = na || nb;
    eq  = !un && (ka == kb);
    lt  = !un && (ka < kb);
    cmp = v && (fn >= 6'd48);
    inv = cmp && ((fn[3] && un) || sa || sb);
    val = (fn[0] && un) || (fn[1] && eq) || (fn[2] && lt);
    we  = cmp && !(inv && tr);
    return {we, cmp ? ix : 3'd0, we && val, inv};
  endfunction

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: {we,idx,val,inv} actual=%b expected=%b", tag, act, expv);
    end
  endtask

  task automatic drive(input logic v, input logic d, input logic [5:0] fn, input logic [2:0] ix,
                       input logic [63:0] a, input logic [63:0] b, input logic tr,
                       input string tag);
    logic [5:0] expv;
    @(negedge clk);
    valid_i = v; fmt_i = d; func_i = fn; cc_idx_i = ix;
    op_a_i = a; op_b_i = b; inv_trap_en_i = tr;
    expv = model(v, d, fn, ix, a, b, tr);
    @(posedge clk);
    #1;
    check(tag, {cc_we_o, cc_idx_o, cc_val_o, inv_o}, expv);
  endtask

  function automatic logic [63:0] pick(input logic d, input int sel, input logic [63:0] rnd);
    case (sel)
      0: pick = d ? 64'h0 : {rnd[63:32], 32'h0};
      1: pick = d ? 64'h8000000000000000 : {rnd[63:32], 32'h80000000};
      2: pick = d ? 64'h3ff0000000000000 : {rnd[63:32], 32'h3f800000};
      3: pick = d ? 64'hbff0000000000000 : {rnd[63:32], 32'hbf800000};
      4: pick = d ? 64'h4000000000000000 : {rnd[63:32], 32'h40000000};
      5: pick = d ? 64'h7ff0000000000000 : {rnd[63:32], 32'h7f800000};
      6: pick = d ? 64'hfff0000000000000 : {rnd[63:32], 32'hff800000};
      7: pick = d ? 64'h7ff8000000000000 : {rnd[63:32], 32'h7fc00000};
      8: pick = d ? 64'h7ff0000000000001 : {rnd[63:32], 32'h7f800001};
      9: pick = d ? 64'hfff8000000000123 : {rnd[63:32], 32'hffc00123};
      default: pick = rnd;
    endcase
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    check("R11", {cc_we_o, cc_idx_o, cc_val_o, inv_o}, 6'b0);
    @(negedge clk); rst_ni = 1'b1;

    // R2 single-precision relations
    drive(1, 0, 6'd52, 3'd2, 64'h3f800000, 64'h40000000, 0, "R2 olt 1<2");
    drive(1, 0, 6'd50, 3'd5, 64'h3f800000, 64'h3f800000, 0, "R2 eq 1==1");
    drive(1, 0, 6'd52, 3'd1, 64'h40000000, 64'h3f800000, 0, "R2 olt 2<1");
    // R3 mask 0 and mask 7
    drive(1, 0, 6'd48, 3'd3, 64'h3f800000, 64'h3f800000, 0, "R3 mask0");
    drive(1, 0, 6'd55, 3'd4, 64'h40000000, 64'h3f800000, 0, "R3 mask7 a>b");
    drive(1, 0, 6'd55, 3'd4, 64'h3f800000, 64'h40000000, 0, "R3 mask7 a<b");
    // R4 quiet NaN
    drive(1, 0, 6'd49, 3'd6, 64'h7fc00000, 64'h3f800000, 0, "R4 un qnan");
    drive(1, 0, 6'd54, 3'd6, 64'h3f800000, 64'h7fc00000, 0, "R4 ole qnan");
    // R5 signaling compare on unordered
    drive(1, 0, 6'd60, 3'd7, 64'h7fc00000, 64'h3f800000, 0, "R5 sig qnan");
    // R6 signaling NaN on quiet compare
    drive(1, 0, 6'd50, 3'd0, 64'h3f800000, 64'h7f800001, 0, "R6 snan quiet cmp");
    drive(1, 1, 6'd49, 3'd1, 64'h7ff0000000000001, 64'h0, 0, "R6 snan dbl");
    // R7 signed zeros
    drive(1, 0, 6'd50, 3'd2, 64'h0, 64'h80000000, 0, "R7 +0==-0");
    drive(1, 0, 6'd52, 3'd2, 64'h80000000, 64'h0, 0, "R7 -0<+0");
    // R8 ordering
    drive(1, 0, 6'd52, 3'd3, 64'hff800000, 64'hbf800000, 0, "R8 -inf<-1");
    drive(1, 0, 6'd52, 3'd3, 64'hc0000000, 64'hbf800000, 0, "R8 -2<-1");
    drive(1, 0, 6'd52, 3'd3, 64'h7f800000, 64'h3f800000, 0, "R8 +inf<1");
    // R9 trap blocks write
    drive(1, 0, 6'd58, 3'd5, 64'h7fc00000, 64'h3f800000, 1, "R9 trap sig");
    drive(1, 0, 6'd50, 3'd5, 64'h7f800001, 64'h7f800001, 1, "R9 trap snan");
    drive(1, 0, 6'd50, 3'd5, 64'h3f800000, 64'h3f800000, 1, "R9 trap no inv");
    // R10 formats
    drive(1, 1, 6'd52, 3'd6, 64'h3ff0000000000000, 64'h4000000000000000, 0, "R10 dbl lt");
    drive(1, 0, 6'd50, 3'd6, 64'hffffffff3f800000, 64'h000000003f800000, 0, "R10 upper ignored");
    drive(1, 1, 6'd50, 3'd6, 64'hffffffff3f800000, 64'h000000003f800000, 0, "R10 dbl sees upper");
    // R1 no request / non-compare
    drive(0, 0, 6'd50, 3'd7, 64'h3f800000, 64'h3f800000, 0, "R1 idle");
    drive(1, 0, 6'd5,  3'd7, 64'h7f800001, 64'h3f800000, 0, "R1 noncmp");
    drive(1, 0, 6'd47, 3'd7, 64'h3f800000, 64'h3f800000, 0, "R1 below range");

    // R2 crossed sweep of specials, all codes, both formats
    for (int k = 0; k < 3000; k++) begin
      logic d, tr, v;
      logic [63:0] ra, rb;
      d  = 1'($urandom_range(0, 1));
      tr = 1'($urandom_range(0, 1));
      v  = ($urandom_range(0, 7) != 0);
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      drive(v, d, 6'(48 + $urandom_range(0, 15)), 3'($urandom_range(0, 7)),
            pick(d, $urandom_range(0, 11), ra), pick(d, $urandom_range(0, 11), rb),
            tr, "R2 sweep");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule